// File: doc/BRIEF.md
# Serial Transceiver Interrupt Request Logic

This block turns the status of a multiprotocol serial transceiver into interrupt requests for a CPU. The receiver and the transmitter supply pending-status levels: three receive error sources (overrun, parity, framing), address match, break, receive data ready, transmit buffer empty and transmit shift register empty. The DMA engine supplies one-cycle end-of-block strobes for each direction. A single 8-bit control register, written and read over a simple register bus, holds five enable masks, a select bit for the transmitter-empty source and two sticky end-of-block flags.

Five separate registered interrupt levels come out: receive error, address, break, receive data and transmit data. The end-of-block flags are set only by hardware and cleared only by software. The DMA request lines pass through the block untouched, so the data masks never stall a DMA transfer.

Top module: `sci_irq_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 and all five interrupt outputs are 0.
- R2: A cycle with `reg_wr` high stores `reg_wdata` bits 7 and 4..0. These bits read back on `reg_rdata` from the next cycle. Bit 7 is the transmit-empty source select, bit 4 the receive-error enable, bit 3 the address enable, bit 2 the break enable, bit 1 the receive-data enable and bit 0 the transmit-data enable.
- R3: A pulse on `rx_eob_evt` sets the receive end-of-block flag, read as bit 6, from the next cycle. A pulse on `tx_eob_evt` sets the transmit end-of-block flag, read as bit 5.
- R4: A flag is cleared only by a register write with a 0 in its bit. Writing a 1 to bit 6 or bit 5 never sets the flag, and with no event and no clearing write the flag holds its value.
- R5: When a hardware set and a software clear of the same flag fall in the same cycle, the flag is 1 afterwards.
- R6: `irq_rx_err` equals, one cycle later, bit 4 AND the OR of the three error pending bits.
- R7: `irq_addr` equals, one cycle later, bit 3 AND `addr_pnd`. `irq_break` equals, one cycle later, bit 2 AND `brk_pnd`.
- R8: `irq_rx_data` equals, one cycle later, bit 1 AND (`rx_rdy_pnd` OR the receive end-of-block flag).
- R9: `irq_tx_data` equals, one cycle later, bit 0 AND (selected empty source OR the transmit end-of-block flag). The source is `tx_buf_empty` when bit 7 is 1 and `tx_shift_empty` when bit 7 is 0.
- R10: `rx_dma_req` and `tx_dma_req` equal `rx_dma_req_in` and `tx_dma_req_in` in the same cycle, whatever the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: masks, select and flags |
| err_pnd | input | ERR_W (3) | Receive error pending bits: overrun, parity, framing |
| addr_pnd | input | 1 | Address match pending |
| brk_pnd | input | 1 | Break pending |
| rx_rdy_pnd | input | 1 | Receive data pending |
| tx_buf_empty | input | 1 | Transmit buffer register empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| rx_eob_evt | input | 1 | Receive DMA end-of-block strobe |
| tx_eob_evt | input | 1 | Transmit DMA end-of-block strobe |
| rx_dma_req_in | input | 1 | Receive DMA request from the receiver |
| tx_dma_req_in | input | 1 | Transmit DMA request from the transmitter |
| irq_rx_err | output | 1 | Receive error interrupt level |
| irq_addr | output | 1 | Address interrupt level |
| irq_break | output | 1 | Break interrupt level |
| irq_rx_data | output | 1 | Receive data / end-of-block interrupt level |
| irq_tx_data | output | 1 | Transmit empty / end-of-block interrupt level |
| rx_dma_req | output | 1 | Receive DMA request, unmasked |
| tx_dma_req | output | 1 | Transmit DMA request, unmasked |

## Verification
A wrong mask or select bit is visible on `reg_rdata` one cycle after the write. It also shows as a wrong interrupt level one cycle after the next matching pending input. A sticky flag that is lost, or set by a write of 1, shows on bit 6 or 5 of the read data in the next cycle. With its data mask enabled, it also keeps the receive- or transmit-data interrupt wrong for as long as the flag is wrong. The bench mixes random pending levels, events and occasional writes with directed cases for the set-versus-clear collision. It compares every output against its model on every clock.

// File: rtl/sci_irq_pkg.sv
package sci_irq_pkg;

    localparam int REG_W      = 8;
    localparam int BIT_SRCSEL = 7;
    localparam int BIT_RXEOB  = 6;
    localparam int BIT_TXEOB  = 5;
    localparam int BIT_RXERR  = 4;
    localparam int BIT_ADDR   = 3;
    localparam int BIT_BREAK  = 2;
    localparam int BIT_RXDATA = 1;
    localparam int BIT_TXDATA = 0;
    localparam int NUM_EOB    = 2;

    // Software-owned part of the control register
    typedef struct packed {
        logic tx_src_buf;
        logic en_rx_err;
        logic en_addr;
        logic en_break;
        logic en_rx_data;
        logic en_tx_data;
    } mask_t;

    // Full register view, bit 7 down to bit 0
    typedef struct packed {
        logic tx_src_buf;
        logic rx_eob;
        logic tx_eob;
        logic en_rx_err;
        logic en_addr;
        logic en_break;
        logic en_rx_data;
        logic en_tx_data;
    } ctl_reg_t;

    typedef struct packed {
        logic rx_err;
        logic addr;
        logic brk;
        logic rx_data;
        logic tx_data;
    } irq_t;

endpackage

// File: rtl/sci_irq_stickyflag.sv
module sci_irq_stickyflag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (sw_clr) flag_d = 1'b0;
        if (hw_set) flag_d = 1'b1;   // hardware wins a collision
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R3 / R5: a hardware event always leaves the flag set
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> flag_q);

    // R4: without an event the flag cannot rise
    assert_no_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !hw_set) |=> !flag_q);

    // R4: without a clearing write the flag cannot fall
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !sw_clr) |=> flag_q);

endmodule

// File: rtl/sci_irq_ctlreg.sv
module sci_irq_ctlreg
    import sci_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             rx_eob_set,
    input  logic             tx_eob_set,
    output ctl_reg_t         ctl
);
    mask_t mask_d, mask_q;
    logic [NUM_EOB-1:0] eob_set, eob_clr, eob_flag;

    assign eob_set = {rx_eob_set, tx_eob_set};

    always_comb begin
        mask_d = mask_q;
        if (wr) begin
            mask_d.tx_src_buf = wdata[BIT_SRCSEL];
            mask_d.en_rx_err  = wdata[BIT_RXERR];
            mask_d.en_addr    = wdata[BIT_ADDR];
            mask_d.en_break   = wdata[BIT_BREAK];
            mask_d.en_rx_data = wdata[BIT_RXDATA];
            mask_d.en_tx_data = wdata[BIT_TXDATA];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // index 1 = receive flag, index 0 = transmit flag
    for (genvar i = 0; i < NUM_EOB; i++) begin : g_eob
        localparam int POS = (i == 1) ? BIT_RXEOB : BIT_TXEOB;
        assign eob_clr[i] = wr && !wdata[POS];
        sci_irq_stickyflag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (eob_set[i]),
            .sw_clr (eob_clr[i]),
            .flag   (eob_flag[i])
        );
    end

    always_comb begin
        ctl.tx_src_buf = mask_q.tx_src_buf;
        ctl.rx_eob     = eob_flag[1];
        ctl.tx_eob     = eob_flag[0];
        ctl.en_rx_err  = mask_q.en_rx_err;
        ctl.en_addr    = mask_q.en_addr;
        ctl.en_break   = mask_q.en_break;
        ctl.en_rx_data = mask_q.en_rx_data;
        ctl.en_tx_data = mask_q.en_tx_data;
    end

    // R2: a written select bit is visible on the next cycle
    assert_write_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ctl.tx_src_buf == $past(wdata[BIT_SRCSEL])));

    // R2: masks do not move without a write
    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mask_q));

endmodule

// File: rtl/sci_irq_reqgen.sv
module sci_irq_reqgen
    import sci_irq_pkg::*;
#(
    parameter int ERR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_reg_t         ctl,
    input  logic [ERR_W-1:0] err_pnd,
    input  logic             addr_pnd,
    input  logic             brk_pnd,
    input  logic             rx_rdy_pnd,
    input  logic             tx_buf_empty,
    input  logic             tx_shift_empty,
    output irq_t             irq
);
    irq_t irq_d, irq_q;
    logic tx_empty_src;

    always_comb begin
        tx_empty_src  = ctl.tx_src_buf ? tx_buf_empty : tx_shift_empty;
        irq_d.rx_err  = ctl.en_rx_err  && (|err_pnd);
        irq_d.addr    = ctl.en_addr    && addr_pnd;
        irq_d.brk     = ctl.en_break   && brk_pnd;
        irq_d.rx_data = ctl.en_rx_data && (rx_rdy_pnd || ctl.rx_eob);
        irq_d.tx_data = ctl.en_tx_data && (tx_empty_src || ctl.tx_eob);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R6: masked errors never raise the request
    assert_rxerr_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.en_rx_err |=> !irq_q.rx_err);

    // R7: an enabled address match raises the request
    assert_addr_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.en_addr && addr_pnd) |=> irq_q.addr);

    // R8: a sticky receive end-of-block keeps the data request up
    assert_rxeob_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.en_rx_data && ctl.rx_eob) |=> irq_q.rx_data);

    // R9: masked transmit data never raises the request
    assert_txdata_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.en_tx_data |=> !irq_q.tx_data);

    // R9: with buffer source selected, shift-empty alone does nothing
    assert_txsrc_buf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.tx_src_buf && !tx_buf_empty && !ctl.tx_eob) |=> !irq_q.tx_data);

endmodule

// File: rtl/sci_irq_ctrl.sv
module sci_irq_ctrl
    import sci_irq_pkg::*;
#(
    parameter int ERR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [ERR_W-1:0] err_pnd,
    input  logic             addr_pnd,
    input  logic             brk_pnd,
    input  logic             rx_rdy_pnd,
    input  logic             tx_buf_empty,
    input  logic             tx_shift_empty,
    input  logic             rx_eob_evt,
    input  logic             tx_eob_evt,
    input  logic             rx_dma_req_in,
    input  logic             tx_dma_req_in,
    output logic             irq_rx_err,
    output logic             irq_addr,
    output logic             irq_break,
    output logic             irq_rx_data,
    output logic             irq_tx_data,
    output logic             rx_dma_req,
    output logic             tx_dma_req
);
    ctl_reg_t ctl;
    irq_t     irq;

    sci_irq_ctlreg u_ctlreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .rx_eob_set (rx_eob_evt),
        .tx_eob_set (tx_eob_evt),
        .ctl        (ctl)
    );

    sci_irq_reqgen #(.ERR_W(ERR_W)) u_reqgen (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctl            (ctl),
        .err_pnd        (err_pnd),
        .addr_pnd       (addr_pnd),
        .brk_pnd        (brk_pnd),
        .rx_rdy_pnd     (rx_rdy_pnd),
        .tx_buf_empty   (tx_buf_empty),
        .tx_shift_empty (tx_shift_empty),
        .irq            (irq)
    );

    assign reg_rdata   = ctl;
    assign irq_rx_err  = irq.rx_err;
    assign irq_addr    = irq.addr;
    assign irq_break   = irq.brk;
    assign irq_rx_data = irq.rx_data;
    assign irq_tx_data = irq.tx_data;

    // R10: DMA requests bypass every mask
    assign rx_dma_req  = rx_dma_req_in;
    assign tx_dma_req  = tx_dma_req_in;

    // R3: end-of-block event shows on the read data one cycle later
    assert_rdata_eob_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eob_evt |=> reg_rdata[BIT_RXEOB]);

endmodule

// File: tb/tb_sci_irq_ctrl.sv
`timescale 1ns/1ps
module tb_sci_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [2:0] err_pnd = 3'b000;
    logic addr_pnd = 0, brk_pnd = 0, rx_rdy_pnd = 0;
    logic tx_buf_empty = 0, tx_shift_empty = 0;
    logic rx_eob_evt = 0, tx_eob_evt = 0;
    logic rx_dma_req_in = 0, tx_dma_req_in = 0;
    logic irq_rx_err, irq_addr, irq_break, irq_rx_data, irq_tx_data;
    logic rx_dma_req, tx_dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_sw;          // bits 7 and 4..0 as last written
    logic       m_frx, m_ftx;  // sticky flags
    logic [4:0] m_irq;         // rx_err, addr, brk, rx_data, tx_data

    always #2 clk = ~clk;      // 250 MHz

    sci_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_pnd(err_pnd), .addr_pnd(addr_pnd),
        .brk_pnd(brk_pnd), .rx_rdy_pnd(rx_rdy_pnd), .tx_buf_empty(tx_buf_empty),
        .tx_shift_empty(tx_shift_empty), .rx_eob_evt(rx_eob_evt),
        .tx_eob_evt(tx_eob_evt), .rx_dma_req_in(rx_dma_req_in),
        .tx_dma_req_in(tx_dma_req_in), .irq_rx_err(irq_rx_err),
        .irq_addr(irq_addr), .irq_break(irq_break), .irq_rx_data(irq_rx_data),
        .irq_tx_data(irq_tx_data), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata();
        return {m_sw[7], m_frx, m_ftx, m_sw[4:0]};
    endfunction

    task automatic compare_all();
        chk("R2 R3 R4 R5", "reg_rdata", reg_rdata, exp_rdata());
        chk("R6", "irq_rx_err", {7'd0, irq_rx_err}, {7'd0, m_irq[4]});
        chk("R7", "irq_addr", {7'd0, irq_addr}, {7'd0, m_irq[3]});
        chk("R7", "irq_break", {7'd0, irq_break}, {7'd0, m_irq[2]});
        chk("R8", "irq_rx_data", {7'd0, irq_rx_data}, {7'd0, m_irq[1]});
        chk("R9", "irq_tx_data", {7'd0, irq_tx_data}, {7'd0, m_irq[0]});
        chk("R10", "dma", {6'd0, rx_dma_req, tx_dma_req},
            {6'd0, rx_dma_req_in, tx_dma_req_in});
    endtask

    // one clock: model next state from present inputs, then compare at negedge
    task automatic step();
        logic [7:0] n_sw;
        logic       n_frx, n_ftx, src;
        logic [4:0] n_irq;
        src      = m_sw[7] ? tx_buf_empty : tx_shift_empty;
        n_irq[4] = m_sw[4] & (err_pnd != 3'b000);
        n_irq[3] = m_sw[3] & addr_pnd;
        n_irq[2] = m_sw[2] & brk_pnd;
        n_irq[1] = m_sw[1] & (rx_rdy_pnd | m_frx);
        n_irq[0] = m_sw[0] & (src | m_ftx);
        n_frx    = rx_eob_evt | (m_frx & !(reg_wr && !reg_wdata[6]));
        n_ftx    = tx_eob_evt | (m_ftx & !(reg_wr && !reg_wdata[5]));
        n_sw     = reg_wr ? reg_wdata : m_sw;
        @(posedge clk);
        #1;
        m_sw = n_sw; m_frx = n_frx; m_ftx = n_ftx; m_irq = n_irq;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        reg_wr = 0; err_pnd = 0; addr_pnd = 0; brk_pnd = 0; rx_rdy_pnd = 0;
        tx_buf_empty = 0; tx_shift_empty = 0; rx_eob_evt = 0; tx_eob_evt = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        idle(); reg_wr = 1; reg_wdata = d; step(); reg_wr = 0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        m_sw = 0; m_frx = 0; m_ftx = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reg_rdata reset", reg_rdata, 8'h00);
        chk("R1", "irqs reset", {3'd0, irq_rx_err, irq_addr, irq_break, irq_rx_data, irq_tx_data}, 8'h00);
        rst_n = 1;
        step();

        // R2: write and read back, flags untouched by writing 1
        wr(8'hFF);
        chk("R4", "write 1 to flags does not set", {6'd0, reg_rdata[6:5]}, 8'h00);
        wr(8'h9A);
        chk("R2", "readback 0x9A less flags", reg_rdata, 8'h9A & 8'h9F);

        // R3: hardware sets, R4: holds, then clears by 0
        idle(); rx_eob_evt = 1; step(); rx_eob_evt = 0;
        chk("R3", "rx flag set", {7'd0, reg_rdata[6]}, 8'd1);
        idle(); tx_eob_evt = 1; step(); tx_eob_evt = 0;
        chk("R3", "tx flag set", {7'd0, reg_rdata[5]}, 8'd1);
        repeat (3) step();
        wr(8'h7F);    // writes 1 to both flags: hold
        chk("R4", "flags held on write 1", {6'd0, reg_rdata[6:5]}, 8'd3);
        wr(8'h5F);    // clear tx only
        chk("R4", "tx cleared rx kept", {6'd0, reg_rdata[6:5]}, 8'd2);

        // R5: collision, hardware wins
        idle(); reg_wr = 1; reg_wdata = 8'h1F; rx_eob_evt = 1; tx_eob_evt = 1; step();
        chk("R5", "set beats clear", {6'd0, reg_rdata[6:5]}, 8'd3);
        wr(8'h1F);
        chk("R4", "both cleared", {6'd0, reg_rdata[6:5]}, 8'd0);

        // R9: source select, shift vs buffer
        wr(8'h01); idle(); tx_shift_empty = 1; step(); step();
        chk("R9", "shift source raises", {7'd0, irq_tx_data}, 8'd1);
        wr(8'h81); idle(); tx_shift_empty = 1; step(); step();
        chk("R9", "shift ignored when buffer selected", {7'd0, irq_tx_data}, 8'd0);

        // R10: DMA passes with masks off
        wr(8'h00); idle(); rx_dma_req_in = 1; tx_dma_req_in = 1; step();
        chk("R10", "dma with masks off", {6'd0, rx_dma_req, tx_dma_req}, 8'd3);
        rx_dma_req_in = 0; tx_dma_req_in = 0;

        // random traffic for R6..R10 with sparse writes
        for (int i = 0; i < 3000; i++) begin
            reg_wr         = ($urandom_range(0, 15) == 0);
            reg_wdata      = 8'($urandom);
            err_pnd        = ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'd0;
            addr_pnd       = 1'($urandom);
            brk_pnd        = 1'($urandom);
            rx_rdy_pnd     = ($urandom_range(0, 3) == 0);
            tx_buf_empty   = 1'($urandom);
            tx_shift_empty = 1'($urandom);
            rx_eob_evt     = ($urandom_range(0, 20) == 0);
            tx_eob_evt     = ($urandom_range(0, 20) == 0);
            rx_dma_req_in  = 1'($urandom);
            tx_dma_req_in  = 1'($urandom);
            step();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule